// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block performs processor state changes at interrupt entry for a small 32-bit core. It watches a reset request, a non-maskable request (NMI) and six maskable request lines. When it accepts a source it saves the current program counter and status word into a save pair, rewrites the status word and the cause register, and puts the vector address on the fetch output. At the same time it raises a one-cycle take pulse that carries the index of the chosen source. Every entry completes in a single clock.

The block owns the status word, the cause register and two save pairs. One save pair belongs to the NMI path and the other to the maskable path. The core supplies the current program counter on `cur_pc`. When the core sees `take`, it loads `fetch_pc`.

A return-from-NMI strobe ends NMI service. An NMI that arrives during NMI service is not dropped and is not counted. It sets a single pending flag, and that flag is replayed once after the return strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the following are all zero: the status word, the cause register, both save pairs, `fetch_pc`, `nmi_pending` and `take`.
- R2: A reset request has the highest priority. At the clock edge that samples it, the block sets `fetch_pc` to 0, the status word to 0x20 and the cause register to 0, and clears `nmi_pending`. It pulses `take` with `take_src` = 0 and leaves both save pairs unchanged.
- R3: Status bit 5 is the interrupt-disable bit and bit 6 is the exception-pending bit. On every NMI or maskable entry, the saved status word is the old status with bit 5 set and bit 6 cleared. The new status word also keeps bit 5 set.
- R4: Status bit 7 is the NMI-in-progress bit. When an NMI is accepted while bit 7 is clear, `cur_pc` goes to `nmi_epc` and the adjusted status goes to `nmi_esw`. The cause register becomes (old & 0x0000FFFF) | 0x10. Bit 7 is set, `fetch_pc` becomes 0x10, and `take` pulses with `take_src` = 1.
- R5: An NMI request that arrives while bit 7 is set only sets `nmi_pending`. There is no take pulse and no other state changes. Repeated requests are not counted.
- R6: Maskable source k (k = 0 to 5) is accepted when bit 5 is clear. On acceptance, `cur_pc` goes to `mi_epc` and the adjusted status goes to `mi_esw`. The cause register becomes (old & 0xFFFF0000) | V, where V = 0x80 + 0x10*k, and `fetch_pc` becomes V. `take` pulses with `take_src` = 2 + k.
- R7: Maskable requests are ignored while status bit 5 is set: no take pulse, and the cause register and the maskable save pair are unchanged.
- R8: An NMI wins over any maskable request in the same cycle. Among maskable requests, the lowest index wins.
- R9: A return strobe clears status bit 7. If `nmi_pending` is set, the strobe also clears it, and the NMI is entered at the following clock edge, with a single take pulse.
- R10: `take` is high only in the cycle after an edge that accepted a source. `fetch_pc` holds its value between entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cur_pc | input | 32 | Program counter of the core, saved on entry |
| rst_req | input | 1 | Reset interrupt request |
| nmi_req | input | 1 | Non-maskable request |
| mi_req | input | 6 | Maskable requests, index 0 highest priority |
| nmi_ret | input | 1 | Return-from-NMI strobe |
| take | output | 1 | One-cycle entry pulse |
| take_src | output | 3 | Source taken: 0 reset, 1 NMI, 2+k maskable k |
| fetch_pc | output | 32 | Vector address to fetch |
| status | output | 32 | Status word |
| cause | output | 32 | Cause register |
| nmi_epc | output | 32 | NMI saved program counter |
| nmi_esw | output | 32 | NMI saved status word |
| mi_epc | output | 32 | Maskable saved program counter |
| mi_esw | output | 32 | Maskable saved status word |
| nmi_pending | output | 1 | Held NMI awaiting release |

## Verification
A request applied before a clock edge produces its take pulse, vector, cause value and save registers immediately after that edge. The bench drives each request on a falling edge and checks the outputs on the next falling edge. The one exception is the replayed NMI, which is due one edge later than the return strobe. For that case the bench checks that there is no take pulse on the strobe's own cycle and that the take pulse appears on the cycle after. Requests that must be ignored are held for one edge, after which the bench confirms that `take`, the cause register and the save pair have not changed.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int XLEN = 32,
  parameter int NSRC = 6,
  parameter int ID_BIT = 5,
  parameter int EP_BIT = 6,
  parameter int NP_BIT = 7,
  parameter logic [XLEN-1:0] RST_SW = 32'h20,
  parameter logic [XLEN-1:0] NMI_VEC = 32'h10,
  parameter logic [XLEN-1:0] MI_BASE = 32'h80,
  parameter logic [XLEN-1:0] MI_STEP = 32'h10,
  localparam int SW = $clog2(NSRC + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            rst_req,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] mi_req,
  input  logic            nmi_ret,
  output logic            take,
  output logic [SW-1:0]   take_src,
  output logic [XLEN-1:0] fetch_pc,
  output logic [XLEN-1:0] status,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] nmi_epc,
  output logic [XLEN-1:0] nmi_esw,
  output logic [XLEN-1:0] mi_epc,
  output logic [XLEN-1:0] mi_esw,
  output logic            nmi_pending
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] ID_M = XLEN'(1) << ID_BIT;
  localparam logic [XLEN-1:0] EP_M = XLEN'(1) << EP_BIT;
  localparam logic [XLEN-1:0] NP_M = XLEN'(1) << NP_BIT;
  localparam logic [XLEN-1:0] LO_M = {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};

  logic            replay;
  logic            mi_any;
  logic [SW-1:0]   mi_src;
  logic [XLEN-1:0] mi_vec;

  always_comb begin
    mi_any = 1'b0;
    mi_src = '0;
    mi_vec = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (mi_req[k]) begin
        mi_any = 1'b1;
        mi_src = SW'(k + 2);
        mi_vec = MI_BASE + MI_STEP * XLEN'(k);
      end
    end
  end

  wire             in_nmi   = status[NP_BIT];
  wire             nmi_fire = nmi_req | replay;
  wire             go_nmi   = !rst_req && nmi_fire && !in_nmi;
  wire             go_mi    = !rst_req && !nmi_fire && mi_any && !status[ID_BIT];
  wire [XLEN-1:0]  entry_sw = (status | ID_M) & ~EP_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take        <= 1'b0;
      take_src    <= '0;
      fetch_pc    <= '0;
      status      <= '0;
      cause       <= '0;
      nmi_epc     <= '0;
      nmi_esw     <= '0;
      mi_epc      <= '0;
      mi_esw      <= '0;
      nmi_pending <= 1'b0;
      replay      <= 1'b0;
    end else begin
      take   <= 1'b0;
      replay <= 1'b0;
      if (rst_req) begin
        take        <= 1'b1;
        take_src    <= '0;
        fetch_pc    <= '0;
        status      <= RST_SW;
        cause       <= '0;
        nmi_pending <= 1'b0;
      end else begin
        if (go_nmi) begin
          nmi_epc  <= cur_pc;
          nmi_esw  <= entry_sw;
          cause    <= (cause & LO_M) | NMI_VEC;
          status   <= entry_sw | NP_M;
          fetch_pc <= NMI_VEC;
          take     <= 1'b1;
          take_src <= SW'(1);
        end else if (go_mi) begin
          mi_epc   <= cur_pc;
          mi_esw   <= entry_sw;
          cause    <= (cause & ~LO_M) | mi_vec;
          status   <= entry_sw;
          fetch_pc <= mi_vec;
          take     <= 1'b1;
          take_src <= mi_src;
        end
        if (nmi_ret && !go_nmi) begin
          status[NP_BIT] <= 1'b0;
          replay         <= nmi_pending | (nmi_req & in_nmi);
          nmi_pending    <= 1'b0;
        end else if (nmi_req && in_nmi) begin
          nmi_pending <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int XLEN = 32,
  parameter int SW = 3,
  parameter int ID_BIT = 5,
  parameter int EP_BIT = 6,
  parameter int NP_BIT = 7,
  parameter logic [XLEN-1:0] RST_SW = 32'h20,
  parameter logic [XLEN-1:0] NMI_VEC = 32'h10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_req,
  input logic            nmi_ret,
  input logic            take,
  input logic [SW-1:0]   take_src,
  input logic [XLEN-1:0] fetch_pc,
  input logic [XLEN-1:0] status,
  input logic [XLEN-1:0] cause,
  input logic [XLEN-1:0] mi_esw,
  input logic            nmi_pending
);
  localparam int HALF = XLEN / 2;

  a_r2_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_src == SW'(0) |-> status == RST_SW && cause == '0 && fetch_pc == '0);

  a_r3_disabled_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> status[ID_BIT] && !status[EP_BIT]);

  a_r4_nmi_marks_progress: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_src == SW'(1) |-> status[NP_BIT] && fetch_pc == NMI_VEC);

  a_r5_pending_only_in_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pending |-> status[NP_BIT]);

  a_r6_code_matches_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_src >= SW'(2) |-> fetch_pc[HALF-1:0] == cause[HALF-1:0] && mi_esw[ID_BIT]);

  a_r7_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_src >= SW'(2) |-> !$past(status[ID_BIT]));

  a_r9_pending_replayed: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ret && nmi_pending && !rst_req ##1 !rst_req |=> take && take_src == SW'(1));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .XLEN(XLEN), .SW(SW), .ID_BIT(ID_BIT), .EP_BIT(EP_BIT), .NP_BIT(NP_BIT),
  .RST_SW(RST_SW), .NMI_VEC(NMI_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_ret(nmi_ret),
  .take(take), .take_src(take_src), .fetch_pc(fetch_pc), .status(status),
  .cause(cause), .mi_esw(mi_esw), .nmi_pending(nmi_pending)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        rst_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic [5:0]  mi_req = '0;
  logic        nmi_ret = 1'b0;
  logic        take;
  logic [2:0]  take_src;
  logic [31:0] fetch_pc, status, cause, nmi_epc, nmi_esw, mi_epc, mi_esw;
  logic        nmi_pending;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .rst_req(rst_req),
    .nmi_req(nmi_req), .mi_req(mi_req), .nmi_ret(nmi_ret),
    .take(take), .take_src(take_src), .fetch_pc(fetch_pc),
    .status(status), .cause(cause), .nmi_epc(nmi_epc), .nmi_esw(nmi_esw),
    .mi_epc(mi_epc), .mi_esw(mi_esw), .nmi_pending(nmi_pending)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    {rst_req, nmi_req, mi_req, nmi_ret} = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_r1_reset_state();
    hw_reset();
    chk("R1 take", {31'b0, take}, 0);
    chk("R1 status", status, 0);
    chk("R1 cause", cause, 0);
    chk("R1 fetch", fetch_pc, 0);
    chk("R1 pending", {31'b0, nmi_pending}, 0);
    chk("R1 nmi_epc", nmi_epc, 0);
    chk("R1 mi_esw", mi_esw, 0);
  endtask

  task automatic t_r6_each_maskable();
    for (int k = 0; k < 6; k++) begin
      hw_reset();
      cur_pc = 32'h1000 + 32'(k);
      mi_req = 6'(1 << k);
      step();
      mi_req = '0;
      chk("R6 take", {31'b0, take}, 1);
      chk("R6 src", {29'b0, take_src}, 32'(k + 2));
      chk("R6 fetch", fetch_pc, 32'h80 + 32'h10 * 32'(k));
      chk("R6 cause", cause, 32'h80 + 32'h10 * 32'(k));
      chk("R6 mi_epc", mi_epc, 32'h1000 + 32'(k));
      chk("R3 mi_esw", mi_esw, 32'h20);
      chk("R3 status", status, 32'h20);
      step();
      chk("R10 take drops", {31'b0, take}, 0);
      chk("R10 fetch holds", fetch_pc, 32'h80 + 32'h10 * 32'(k));
    end
  endtask

  task automatic t_r7_masked();
    hw_reset();
    cur_pc = 32'h40;
    mi_req = 6'b000100;
    step();
    mi_req = 6'b000001;
    cur_pc = 32'h44;
    step();
    mi_req = '0;
    chk("R7 no take", {31'b0, take}, 0);
    chk("R7 cause kept", cause, 32'hA0);
    chk("R7 mi_epc kept", mi_epc, 32'h40);
    chk("R7 fetch kept", fetch_pc, 32'hA0);
  endtask

  task automatic t_r8_priority();
    hw_reset();
    mi_req = 6'b101100;
    step();
    mi_req = '0;
    chk("R8 lowest index src", {29'b0, take_src}, 4);
    chk("R8 lowest index vec", fetch_pc, 32'hA0);
    hw_reset();
    nmi_req = 1'b1; mi_req = 6'b000001;
    step();
    nmi_req = 1'b0; mi_req = '0;
    chk("R8 nmi wins src", {29'b0, take_src}, 1);
    chk("R8 mi_epc untouched", mi_epc, 0);
    hw_reset();
    rst_req = 1'b1; nmi_req = 1'b1; mi_req = 6'b000001;
    step();
    {rst_req, nmi_req, mi_req} = '0;
    chk("R2 reset wins src", {29'b0, take_src}, 0);
    chk("R2 take", {31'b0, take}, 1);
    chk("R2 status", status, 32'h20);
    chk("R2 nmi_epc untouched", nmi_epc, 0);
  endtask

  task automatic t_r4_r5_r9_nmi();
    hw_reset();
    cur_pc = 32'h500;
    mi_req = 6'b000001;
    step();
    mi_req = '0;
    cur_pc = 32'h2000;
    nmi_req = 1'b1;
    step();
    nmi_req = 1'b0;
    chk("R4 take", {31'b0, take}, 1);
    chk("R4 src", {29'b0, take_src}, 1);
    chk("R4 fetch", fetch_pc, 32'h10);
    chk("R4 nmi_epc", nmi_epc, 32'h2000);
    chk("R4 nmi_esw", nmi_esw, 32'h20);
    chk("R4 cause", cause, 32'h90);
    chk("R4 status", status, 32'hA0);
    cur_pc = 32'h2100;
    nmi_req = 1'b1;
    step();
    nmi_req = 1'b0;
    chk("R5 no take", {31'b0, take}, 0);
    chk("R5 pending", {31'b0, nmi_pending}, 1);
    chk("R5 nmi_epc kept", nmi_epc, 32'h2000);
    step();
    nmi_req = 1'b1;
    step();
    nmi_req = 1'b0;
    chk("R5 second no take", {31'b0, take}, 0);
    cur_pc = 32'h3000;
    nmi_ret = 1'b1;
    step();
    nmi_ret = 1'b0;
    chk("R9 no take on strobe", {31'b0, take}, 0);
    chk("R9 progress cleared", status, 32'h20);
    chk("R9 pending cleared", {31'b0, nmi_pending}, 0);
    step();
    chk("R9 replay take", {31'b0, take}, 1);
    chk("R9 replay src", {29'b0, take_src}, 1);
    chk("R9 replay epc", nmi_epc, 32'h3000);
    chk("R9 replay status", status, 32'hA0);
    step();
    chk("R5 single replay", {31'b0, take}, 0);
    nmi_ret = 1'b1;
    step();
    nmi_ret = 1'b0;
    step();
    chk("R5 no second replay", {31'b0, take}, 0);
    chk("R9 status idle", status, 32'h20);
  endtask

  task automatic t_r2_reset_req();
    hw_reset();
    nmi_req = 1'b1;
    cur_pc = 32'h700;
    step();
    step();
    nmi_req = 1'b0;
    chk("R5 pending before reset", {31'b0, nmi_pending}, 1);
    rst_req = 1'b1;
    step();
    rst_req = 1'b0;
    chk("R2 fetch", fetch_pc, 0);
    chk("R2 cause", cause, 0);
    chk("R2 status", status, 32'h20);
    chk("R2 pending cleared", {31'b0, nmi_pending}, 0);
    chk("R2 nmi_epc kept", nmi_epc, 32'h700);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_r1_reset_state();
    t_r6_each_maskable();
    t_r7_masked();
    t_r8_priority();
    t_r4_r5_r9_nmi();
    t_r2_reset_req();
    finish_run();
  end
endmodule